// File: doc/BRIEF.md
# Priority-Threshold Interrupt Target Selector

This block is the decision stage for one interrupt target of a platform interrupt controller. It takes a vector of pending flags, the target's per-source enable mask, one priority value per source and the target's threshold. It then finds the enabled, pending source that has the highest priority. The identity of that source is registered onto an ID output. A registered request line rises when the winner's priority is strictly greater than the threshold.

Sources are numbered from 1 to N. Source ID k uses bit k-1 of the pending and enable vectors and bits [(k-1)*PW +: PW] of the packed priority bus. ID 0 means "no source". The selection is a balanced tree of compare-and-select nodes, and the tree is padded up to a power of two. A tie goes to the left input, so the lower ID wins. The reported ID follows the winner even when its priority is too low to raise the request. Software can therefore observe a masked-by-threshold winner.

Top module: `irqsel_target`

## Requirements
- R1: A source takes part in selection only when both its enable bit and its pending bit are 1. Pending-but-disabled or enabled-but-idle sources never affect either output.
- R2: `irq_o` is 1 in the cycle after an edge at which the winning candidate's priority is strictly greater than `thresh_i`, and 0 otherwise.
- R3: A winner whose priority equals the threshold does not raise `irq_o`.
- R4: After each clock edge, `irq_id_o` holds the ID of the winning candidate sampled at that edge, whether or not its priority clears the threshold.
- R5: Among candidates sharing the highest priority, the one with the lowest ID wins.
- R6: A candidate with priority 0 never wins. When no candidate has nonzero priority, `irq_id_o` becomes 0 and `irq_o` stays 0.
- R7: While `rst_ni` is 0, `irq_o` and `irq_id_o` are both 0.
- R8: Whenever `irq_o` is 1, `irq_id_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pending_i | input | N_SRC | Pending flag per source, bit k-1 for ID k |
| enable_i | input | N_SRC | Target enable mask, bit k-1 for ID k |
| prio_i | input | N_SRC*PRIO_W | Packed priorities, field [(k-1)*PRIO_W +: PRIO_W] for ID k |
| thresh_i | input | PRIO_W | Target threshold; strict comparison |
| irq_o | output | 1 | Registered interrupt request |
| irq_id_o | output | $clog2(N_SRC+1) | Registered winner ID, 0 for none |

## Verification
The bench builds the block with N_SRC=6 and PRIO_W=3. Six is not a power of two, so two padding leaves of the tree are always present, and the bench confirms that they never produce a winner. A 3-bit priority gives eight levels, which makes ties and exact-threshold matches frequent under random stimulus. It also lets directed cases reach the top priority 7 and the top threshold 7, where no request can ever be raised.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  // Width needed to carry IDs 0..n.
  function automatic int unsigned id_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Leaf count of the padded selection tree.
  function automatic int unsigned tree_leaves(input int unsigned n);
    return (n <= 1) ? 1 : (1 << $clog2(n));
  endfunction

endpackage

// File: rtl/irqsel_node.sv
module irqsel_node #(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 3
) (
  input  logic [PRIO_W-1:0] lo_prio_i,
  input  logic [ID_W-1:0]   lo_id_i,
  input  logic [PRIO_W-1:0] hi_prio_i,
  input  logic [ID_W-1:0]   hi_id_i,
  output logic [PRIO_W-1:0] win_prio_o,
  output logic [ID_W-1:0]   win_id_o
);

  // The upper-ID side must be strictly greater to win, so ties keep the lower ID.
  function automatic logic take_hi(input logic [PRIO_W-1:0] lo, input logic [PRIO_W-1:0] hi);
    return hi > lo;
  endfunction

  logic sel_hi;

  always_comb begin
    sel_hi     = take_hi(lo_prio_i, hi_prio_i);
    win_prio_o = sel_hi ? hi_prio_i : lo_prio_i;
    win_id_o   = sel_hi ? hi_id_i   : lo_id_i;
  end

  always_comb begin
    if (!$isunknown({lo_prio_i, hi_prio_i})) begin
      AST_NODE_MAX: assert (win_prio_o >= lo_prio_i && win_prio_o >= hi_prio_i); // R5
    end
  end

endmodule

// File: rtl/irqsel_tree.sv
module irqsel_tree
  import irqsel_pkg::*;
#(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned ID_W  = id_width(N_SRC),
  localparam int unsigned LEAVES = tree_leaves(N_SRC),
  localparam int unsigned NODES  = 2 * LEAVES - 1
) (
  input  logic [N_SRC-1:0]        cand_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic [PRIO_W-1:0]       best_prio_o,
  output logic [ID_W-1:0]         best_id_o
);

  // Heap layout: node k has children 2k+1 and 2k+2; leaves start at LEAVES-1.
  logic [PRIO_W-1:0] n_prio [NODES];
  logic [ID_W-1:0]   n_id   [NODES];

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < N_SRC) begin : g_real
      // A non-candidate presents priority 0 and ID 0, so it can never beat anything.
      logic live;
      assign live = cand_i[l] && (prio_i[l*PRIO_W +: PRIO_W] != '0);
      assign n_prio[LEAVES-1+l] = live ? prio_i[l*PRIO_W +: PRIO_W] : '0;
      assign n_id[LEAVES-1+l]   = live ? ID_W'(l + 1) : '0;
    end else begin : g_pad
      assign n_prio[LEAVES-1+l] = '0;
      assign n_id[LEAVES-1+l]   = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    irqsel_node #(
      .PRIO_W(PRIO_W),
      .ID_W  (ID_W)
    ) u_node (
      .lo_prio_i (n_prio[2*k+1]),
      .lo_id_i   (n_id[2*k+1]),
      .hi_prio_i (n_prio[2*k+2]),
      .hi_id_i   (n_id[2*k+2]),
      .win_prio_o(n_prio[k]),
      .win_id_o  (n_id[k])
    );
  end

  assign best_prio_o = n_prio[0];
  assign best_id_o   = n_id[0];

  always_comb begin
    if (!$isunknown({best_prio_o, best_id_o})) begin
      AST_ZERO_NOWIN: assert ((best_id_o != '0) == (best_prio_o != '0)); // R6
      AST_ID_RANGE:   assert (best_id_o <= ID_W'(N_SRC)); // R6
    end
  end

endmodule

// File: rtl/irqsel_out.sv
module irqsel_out #(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRIO_W-1:0] best_prio_i,
  input  logic [ID_W-1:0]   best_id_i,
  input  logic [PRIO_W-1:0] thresh_i,
  output logic              fire_o,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o
);

  // Strict comparison: equal to threshold is not enough.
  function automatic logic clears(input logic [PRIO_W-1:0] p, input logic [PRIO_W-1:0] t);
    return p > t;
  endfunction

  assign fire_o = clears(best_prio_i, thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      irq_id_o <= '0;
    end else begin
      irq_o    <= fire_o;
      irq_id_o <= best_id_i;
    end
  end

  AST_IRQ_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> irq_o); // R2
  AST_IRQ_BWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(best_prio_i) > $past(thresh_i)); // R3
  AST_ID_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_id_o != '0); // R8
  AST_ID_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_id_o != $past(irq_id_o) && irq_id_o != '0)
      |-> (irq_o || ($past(best_id_i) != '0 && !($past(best_prio_i) > $past(thresh_i))))); // R4

endmodule

// File: rtl/irqsel_target.sv
module irqsel_target
  import irqsel_pkg::*;
#(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned ID_W  = id_width(N_SRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        pending_i,
  input  logic [N_SRC-1:0]        enable_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       thresh_i,
  output logic                    irq_o,
  output logic [ID_W-1:0]         irq_id_o
);

  logic [N_SRC-1:0]  cand;
  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   best_id;
  logic              fire;

  assign cand = pending_i & enable_i;

  irqsel_tree #(
    .N_SRC (N_SRC),
    .PRIO_W(PRIO_W)
  ) u_tree (
    .cand_i     (cand),
    .prio_i     (prio_i),
    .best_prio_o(best_prio),
    .best_id_o  (best_id)
  );

  irqsel_out #(
    .PRIO_W(PRIO_W),
    .ID_W  (ID_W)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .best_prio_i(best_prio),
    .best_id_i  (best_id),
    .thresh_i   (thresh_i),
    .fire_o     (fire),
    .irq_o      (irq_o),
    .irq_id_o   (irq_id_o)
  );

  always_comb begin
    if (!$isunknown({best_id, cand})) begin
      AST_WIN_IS_CAND: assert (best_id == '0 || cand[best_id - ID_W'(1)]); // R1
    end
  end

  AST_RST_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> (!irq_o && irq_id_o == '0)); // R7

endmodule

// File: tb/irqsel_target_tb.sv
module irqsel_target_tb;
  localparam int N  = 6;
  localparam int PW = 3;
  localparam int IW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0;
  logic [N-1:0]  en = '0;
  logic [N*PW-1:0] prio = '0;
  logic [PW-1:0] thr = '0;
  logic          irq;
  logic [IW-1:0] irq_id;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqsel_target #(.N_SRC(N), .PRIO_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pending_i(pend), .enable_i(en),
    .prio_i(prio), .thresh_i(thr), .irq_o(irq), .irq_id_o(irq_id)
  );

  // Reference: scan IDs from high to low, replacing on >= so the lowest ID survives ties.
  function automatic int ref_id(input logic [N-1:0] p, input logic [N-1:0] e,
                                input logic [N*PW-1:0] pr);
    int best = 0;
    int bp = 0;
    for (int s = N; s >= 1; s--) begin
      int v = int'(pr[(s-1)*PW +: PW]);
      if (p[s-1] && e[s-1] && v > 0 && v >= bp) begin
        bp = v;
        best = s;
      end
    end
    return best;
  endfunction

  function automatic int ref_prio(input int id, input logic [N*PW-1:0] pr);
    return (id == 0) ? 0 : int'(pr[(id-1)*PW +: PW]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge register, check on the next falling edge.
  task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e,
                       input logic [N*PW-1:0] pr, input logic [PW-1:0] t,
                       input string req);
    int eid;
    int ep;
    @(negedge clk);
    pend = p; en = e; prio = pr; thr = t;
    eid = ref_id(p, e, pr);
    ep  = ref_prio(eid, pr);
    @(negedge clk);
    check({req, " id"}, int'(irq_id), eid);
    check({req, " irq"}, int'(irq), (ep > int'(t)) ? 1 : 0);
  endtask

  function automatic logic [N*PW-1:0] pack(input int a, input int b, input int c,
                                           input int d, input int f, input int g);
    return {PW'(g), PW'(f), PW'(d), PW'(c), PW'(b), PW'(a)};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    pend = '1; en = '1; prio = pack(7,7,7,7,7,7); thr = '0;
    repeat (3) @(negedge clk);
    check("R7 reset irq", int'(irq), 0);
    check("R7 reset id", int'(irq_id), 0);
    @(negedge clk) rst_n = 1'b1;

    // R1: pending without enable, enable without pending
    apply(6'b000100, 6'b001000, pack(1,2,5,6,1,1), 3'd0, "R1 mask");
    apply(6'b111111, 6'b000010, pack(7,3,7,7,7,7), 3'd2, "R1 single");
    // R3: equal to threshold, then one above
    apply(6'b001000, 6'b001000, pack(0,0,0,4,0,0), 3'd4, "R3 equal");
    apply(6'b001000, 6'b001000, pack(0,0,0,5,0,0), 3'd4, "R2 above");
    // R4: winner reported below threshold
    apply(6'b110000, 6'b110000, pack(0,0,0,0,2,3), 3'd6, "R4 below");
    // R5: ties
    apply(6'b101010, 6'b111111, pack(1,5,1,5,1,5), 3'd1, "R5 tie");
    apply(6'b110000, 6'b110000, pack(0,0,0,0,6,6), 3'd0, "R5 tie top");
    // R6: priority zero never wins
    apply(6'b111111, 6'b111111, pack(0,0,0,0,0,0), 3'd0, "R6 zero");
    apply(6'b000001, 6'b000001, pack(0,3,3,3,3,3), 3'd0, "R6 zero lone");
    // top threshold: nothing fires
    apply(6'b111111, 6'b111111, pack(7,7,7,7,7,7), 3'd7, "R3 max thr");
    apply(6'b100000, 6'b100000, pack(0,0,0,0,0,7), 3'd6, "R2 last src");

    // R8 under random load
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] rp;
      logic [N-1:0] re;
      logic [N*PW-1:0] rpr;
      logic [PW-1:0] rt;
      rp  = N'($urandom);
      re  = N'($urandom);
      rpr = (N*PW)'($urandom);
      rt  = PW'($urandom);
      apply(rp, re, rpr, rt, "R2 R4 random");
      if (irq) check("R8 id nonzero", (irq_id != '0) ? 1 : 0, 1);
    end

    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R7 mid reset irq", int'(irq), 0);
    check("R7 mid reset id", int'(irq_id), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule